// File: doc/BRIEF.md
# Unsigned Tree Multiplier with Skip-Carry Final Adder

This block multiplies two unsigned operands and returns their full-width product. Every operand bit pair is ANDed to form a partial-product bit whose weight is the sum of the two bit positions. This gives one shifted row per bit of the second operand. Rows of full adders (3:2 compressors) then fold these rows in layers until only two rows are left. A two-operand adder of the carry-skip kind adds those two rows. The adder is cut into fixed-width blocks. When every bit of a block propagates, the block's incoming carry is routed straight to its outgoing carry and does not ripple through the bits.

The datapath is combinational. The parameter `OUT_REG` places an optional register on the product for timing closure. With `OUT_REG = 0` the product follows the operands in the same cycle, and the clock and reset serve only the embedded checks. With `OUT_REG = 1` the product is captured on the rising clock edge and cleared by the active-low reset. The block has no handshake. It accepts a new operand pair on every cycle, so there is no back-pressure to manage.

Top module: `tree_mult`

## Requirements
- R1: With `OUT_REG = 0`, `product` equals the unsigned product `op_a * op_b`, exact over the full 16-bit width for 8-bit operands, in the same cycle as the operands.
- R2: The partial-product rows sum (modulo 2^16) to `op_a * op_b`, and every compression layer leaves that sum of its rows unchanged.
- R3: After the last layer exactly two rows remain, and their sum modulo 2^16 equals `op_a * op_b`. For 8-bit operands this takes four layers.
- R4: In the final adder, with 4-bit blocks, a block whose bits all propagate (x XOR y = 1 on every bit) delivers its incoming carry as its outgoing carry.
- R5: With `OUT_REG = 1`, `product` equals the product of the operands present at the previous rising clock edge.
- R6: With `OUT_REG = 1`, `product` reads 0 while `rst_n` is low, whatever the operands are.
- R7: Boundary operands give exact results: a zero operand gives 0, 255 x 255 gives 65025 (0xFE01), and 1 x v gives v.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | OP_W (8) | Unsigned multiplicand |
| op_b | input | OP_W (8) | Unsigned multiplier; bit i selects row i |
| product | output | 2*OP_W (16) | Unsigned product |

## Verification
The bench builds two copies side by side, both with 8-bit operands and 4-bit adder blocks: `OUT_REG = 0` and `OUT_REG = 1`. These settings make an exhaustive sweep of all 65,536 operand pairs practical. The sweep drives every carry pattern the four skip blocks can see through both the combinational path and the registered path. The registered copy also makes the reset-clears-output rule observable at the ports. A short table of hand-computed vectors pins down the boundary operands before the sweep runs.

// File: rtl/tree_mult_pkg.sv
package tree_mult_pkg;

  // Rows left after one layer of 3:2 compression over n rows.
  function automatic int rows_next(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Rows present at the input of layer l when starting from n rows.
  function automatic int rows_at(input int n, input int l);
    int r;
    r = n;
    for (int i = 0; i < l; i++) r = rows_next(r);
    return r;
  endfunction

  // Number of layers needed to bring n rows down to two.
  function automatic int layer_count(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_next(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/tm_pp_gen.sv
module tm_pp_gen #(
  parameter int OP_W = 8,
  localparam int PW = 2 * OP_W
) (
  input  logic [OP_W-1:0]          mcand,
  input  logic [OP_W-1:0]          mplier,
  output logic [OP_W-1:0][PW-1:0]  rows
);
  generate
    for (genvar i = 0; i < OP_W; i++) begin : g_row
      logic [PW-1:0] wide;
      assign wide    = {{OP_W{1'b0}}, (mcand & {OP_W{mplier[i]}})};
      assign rows[i] = wide << i;
    end
  endgenerate
endmodule

// File: rtl/tm_csa_layer.sv
module tm_csa_layer #(
  parameter int IN_ROWS = 8,
  parameter int MAXR    = 8,
  parameter int PW      = 16
) (
  input  logic [MAXR-1:0][PW-1:0] rin,
  output logic [MAXR-1:0][PW-1:0] rout
);
  localparam int GROUPS   = IN_ROWS / 3;
  localparam int LEFT     = IN_ROWS % 3;
  localparam int OUT_ROWS = 2 * GROUPS + LEFT;

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_fa
      logic [PW-1:0] x, y, z;
      assign x = rin[3*g];
      assign y = rin[3*g+1];
      assign z = rin[3*g+2];
      assign rout[2*g]   = x ^ y ^ z;
      assign rout[2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
    end
    for (genvar r = 2 * GROUPS; r < MAXR; r++) begin : g_rest
      if (r < OUT_ROWS) begin : g_pass
        assign rout[r] = rin[3*GROUPS + (r - 2*GROUPS)];
      end else begin : g_zero
        assign rout[r] = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/tm_skip_adder.sv
module tm_skip_adder #(
  parameter int W   = 16,
  parameter int BLK = 4,
  localparam int NB = W / BLK
) (
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  output logic [W-1:0]  sum,
  output logic [NB-1:0] blk_cin,
  output logic [NB-1:0] blk_cout,
  output logic [NB-1:0] blk_prop
);
  logic [NB:0] chain;
  assign chain[0] = 1'b0;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_blk
      logic [BLK-1:0] p, g;
      logic [BLK:0]   rc;
      assign p = x[k*BLK +: BLK] ^ y[k*BLK +: BLK];
      assign g = x[k*BLK +: BLK] & y[k*BLK +: BLK];
      always_comb begin
        rc[0] = chain[k];
        for (int j = 0; j < BLK; j++) rc[j+1] = g[j] | (p[j] & rc[j]);
      end
      assign sum[k*BLK +: BLK] = p ^ rc[BLK-1:0];
      assign blk_prop[k]  = &p;
      assign blk_cin[k]   = chain[k];
      assign blk_cout[k]  = blk_prop[k] ? chain[k] : rc[BLK];
      assign chain[k+1]   = blk_cout[k];
    end
  endgenerate
endmodule

// File: rtl/tree_mult.sv
module tree_mult
  import tree_mult_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int BLK_W   = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  output logic [2*OP_W-1:0]   product
);
  localparam int PW = 2 * OP_W;
  localparam int NL = layer_count(OP_W);
  localparam int NB = PW / BLK_W;

  logic [OP_W-1:0][PW-1:0] lrows [0:NL];
  logic [PW-1:0]           lsum  [0:NL];
  logic [PW-1:0]           ref_p;
  logic [PW-1:0]           sum_q;
  logic [NB-1:0]           bcin, bcout, bprop;

  assign ref_p = PW'(op_a) * PW'(op_b);

  tm_pp_gen #(.OP_W(OP_W)) u_pp (
    .mcand (op_a),
    .mplier(op_b),
    .rows  (lrows[0])
  );

  generate
    for (genvar l = 0; l < NL; l++) begin : g_layer
      tm_csa_layer #(
        .IN_ROWS(rows_at(OP_W, l)),
        .MAXR   (OP_W),
        .PW     (PW)
      ) u_layer (
        .rin (lrows[l]),
        .rout(lrows[l+1])
      );
    end
  endgenerate

  tm_skip_adder #(.W(PW), .BLK(BLK_W)) u_add (
    .x       (lrows[NL][0]),
    .y       (lrows[NL][1]),
    .sum     (sum_q),
    .blk_cin (bcin),
    .blk_cout(bcout),
    .blk_prop(bprop)
  );

  always_comb begin
    for (int l = 0; l <= NL; l++) begin
      lsum[l] = '0;
      for (int r = 0; r < OP_W; r++) lsum[l] = lsum[l] + lrows[l][r];
    end
  end

  // R2: partial products carry the full weight of the product
  a_r2_pp_sum: assert property (@(posedge clk) disable iff (!rst_n)
    lsum[0] == ref_p);

  generate
    for (genvar l = 0; l < NL; l++) begin : g_chk
      // R2: each layer keeps the sum of its rows
      a_r2_layer_keep: assert property (@(posedge clk) disable iff (!rst_n)
        lsum[l+1] == lsum[l]);
    end
  endgenerate

  // R3: two surviving rows add to the product
  a_r3_two_rows: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(lrows[NL][0] + lrows[NL][1]) == ref_p);

  // R3: adder output matches the reference
  a_r3_adder_out: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q == ref_p);

  generate
    for (genvar k = 0; k < NB; k++) begin : g_skipchk
      // R4: fully propagating block passes its carry through
      a_r4_skip_pass: assert property (@(posedge clk) disable iff (!rst_n)
        bprop[k] |-> (bcout[k] == bcin[k]));
    end

    if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          product <= '0;
          primed  <= 1'b0;
        end else begin
          product <= sum_q;
          primed  <= 1'b1;
        end
      end
      // R5: registered product lags the operands by one edge
      a_r5_reg_lag: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (product == PW'($past(op_a)) * PW'($past(op_b))));
    end else begin : g_comb
      assign product = sum_q;
      // R1: combinational product is exact
      a_r1_comb_exact: assert property (@(posedge clk) disable iff (!rst_n)
        product == ref_p);
    end
  endgenerate
endmodule

// File: tb/tb_tree_mult.sv
module tb_tree_mult;
  localparam int OP_W = 8;
  localparam int PW   = 16;
  localparam int NV   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OP_W-1:0] a = '0, b = '0;
  logic [PW-1:0] p_comb, p_reg;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tree_mult #(.OP_W(OP_W), .BLK_W(4), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .product(p_comb));

  tree_mult #(.OP_W(OP_W), .BLK_W(4), .OUT_REG(1'b1)) dut_reg (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .product(p_reg));

  localparam logic [OP_W-1:0] VA [NV] = '{8'd0, 8'd255, 8'd0, 8'd1, 8'd128,
                                          8'd15, 8'd170, 8'd255, 8'd16};
  localparam logic [OP_W-1:0] VB [NV] = '{8'd0, 8'd255, 8'd255, 8'd200, 8'd128,
                                          8'd17, 8'd85, 8'd1, 8'd16};
  localparam logic [PW-1:0]   VP [NV] = '{16'd0, 16'hFE01, 16'd0, 16'd200, 16'd16384,
                                          16'd255, 16'd14450, 16'd255, 16'd256};

  task automatic check(input string req, input logic [PW-1:0] got,
                       input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
    end
  endtask

  initial begin
    // R6: reset holds registered product at zero despite nonzero operands
    a = 8'd200; b = 8'd199;
    @(negedge clk); @(negedge clk);
    check("R6 reset", p_reg, 16'd0);
    check("R1 comb in reset", p_comb, 16'd39800);
    rst_n = 1'b1;

    // R7 / R1 / R5: table of boundary vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a = VA[i]; b = VB[i];
      @(negedge clk);
      check("R7 R1 table comb", p_comb, VP[i]);
      check("R7 R5 table reg", p_reg, VP[i]);
    end

    // R1 R2 R3 R4 R5: exhaustive sweep of operand pairs
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        a = x[OP_W-1:0]; b = y[OP_W-1:0];
        @(negedge clk);
        check("R1 R2 R3 R4 sweep comb", p_comb, PW'(x * y));
        check("R5 sweep reg", p_reg, PW'(x * y));
      end
    end

    // R6: reset asserted mid-run clears the register asynchronously
    a = 8'd255; b = 8'd255;
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R6 reset mid-run", p_reg, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 after reset release", p_reg, 16'hFE01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule